// File: doc/BRIEF.md
# UART Receive Idle Timer and Break Driver

This block sits beside a UART receiver and transmitter. It has two jobs. The first is to watch the serial receive input for a quiet period. The second is to let a control bit force the transmit output low.

The idle period is not a fixed cycle count. It is four whole character times, and one character time depends on the frame format currently configured: one start bit, five to eight data bits, an optional parity bit, and one or two stop bits. The block synchronizes the receive line and tracks a 16-step phase inside each bit. At the middle sample of each bit it takes a reading of the line.

Every oversampling tick advances an idle counter. Three things clear the counter: a low reading at a mid-bit sample, the arrival of a new character, and a read of the receive FIFO by the CPU. The timeout output is the idle indication gated by a flag that says the receive FIFO holds unread data. The break input overrides the serializer and drives the line low at once. When break is off, the line follows the serializer, or rests at mark (high) while the serializer is idle.

Top module: `uart_rx_idle_brk`

## Requirements
- R1: After a synchronous active-low reset with the receive line high, `rx_idle` and `rx_timeout` are both 0.
- R2: With the receive line held high, `rx_idle` rises exactly when the counter has seen 64×N ticks since it was last cleared, where N = 1 + D + P + S. Here D = 5 + `cfg_len`, with the encoding 0→5, 1→6, 2→7, 3→8 data bits. P = `cfg_par_en`. S = 1 + `cfg_two_stop`. One tick earlier, `rx_idle` is still 0.
- R3: Clock cycles without a `baud_tick` pulse do not advance the idle count.
- R4: A falling edge seen at a tick restarts the bit phase. The line is read at the 8th tick of the bit, which is 7 ticks after the edge tick. A low reading there clears the count, so `rx_idle` returns exactly 64×N ticks after that reading.
- R5: A low pulse that ends before the mid-bit sample does not clear the count. An asserted `rx_idle` stays asserted through such a pulse.
- R6: A one-cycle `rx_char_done` pulse clears the count, so `rx_idle` is 0 in the following cycle.
- R7: `rx_timeout` is 1 only while both `rx_idle` and `fifo_nonempty` are 1. It follows `fifo_nonempty` within the same cycle.
- R8: A one-cycle `fifo_read` pulse clears the count and drops `rx_timeout` in the next cycle. A timeout is signalled again only after a further 64×N ticks of high line.
- R9: While `brk_force` is 1, `tx_line` is 0 whatever the values of `tx_ser_bit` and `tx_ser_idle`.
- R10: While `brk_force` is 0, `tx_line` equals `tx_ser_bit` when `tx_ser_idle` is 0, and equals 1 when `tx_ser_idle` is 1. The change takes effect in the same cycle that `brk_force` falls.
- R11: Once `rx_idle` is asserted, it stays asserted through further ticks while the line stays high and the configuration does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle enable at 16× the baud rate |
| rx_in | input | 1 | Serial receive line (asynchronous) |
| cfg_len | input | 2 | Data bits: 0→5, 1→6, 2→7, 3→8 |
| cfg_par_en | input | 1 | Parity bit present in the frame |
| cfg_two_stop | input | 1 | Two stop bits when 1, else one |
| brk_force | input | 1 | Force the transmit line low |
| rx_char_done | input | 1 | Pulse: a character was received |
| fifo_nonempty | input | 1 | Receive FIFO holds unread data |
| fifo_read | input | 1 | Pulse: the CPU read a character |
| tx_ser_bit | input | 1 | Serializer output bit |
| tx_ser_idle | input | 1 | Serializer has nothing to send |
| rx_idle | output | 1 | Line has been quiet for four character times |
| rx_timeout | output | 1 | Idle while unread data is waiting |
| tx_line | output | 1 | Transmit line after the break override |

## Verification
The bench sweeps all sixteen frame formats and looks at the exact tick where idle is reached. A threshold built from the wrong bit count, or one that is off by one, shows up as a flag that is early or late by one tick.

Three kinds of low pulse are tested. A low that lasts past the mid-bit sample must restart the count at that sample. A short glitch must be ignored. A design that samples at the wrong phase, or clears on any low, would either miss the first case or drop idle on the glitch.

Gaps with no tick, `fifo_read`, and `rx_char_done` are each checked separately. A design that counts clocks instead of ticks, or that never re-arms after a read, would fail these checks. The break gate is swept over all eight input combinations.

// File: rtl/rxib_pkg.sv
// Shared definitions for the receive idle timer and break driver.
// Assumes the frame format is stable while an idle period is being timed.
package rxib_pkg;

    // Smallest data word a frame can carry
    localparam int unsigned MIN_DATA_BITS  = 5;
    // Longest frame: start + 8 data + parity + 2 stop
    localparam int unsigned MAX_FRAME_BITS = 12;

    // Frame format as configured by software
    typedef struct packed {
        logic [1:0] len;       // data bits minus five
        logic       par_en;    // parity bit present
        logic       two_stop;  // second stop bit present
    } frame_cfg_t;

    // Number of bit periods in one character, start bit included
    function automatic int unsigned frame_bits(input frame_cfg_t c);
        return 1 + MIN_DATA_BITS + int'(c.len) + int'(c.par_en)
             + 1 + int'(c.two_stop);
    endfunction

endpackage

// File: rtl/rxib_phase_track.sv
// Synchronizes the receive line and tracks the sub-bit phase.
// A falling edge seen at a tick restarts the phase. A strobe marks the
// middle sample of each bit and carries the line level seen there.
// Assumes baud_tick is a one-cycle enable spaced wider than the synchronizer.
module rxib_phase_track #(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    output logic mid_strobe,
    output logic mid_level
);
    localparam int PH_W    = $clog2(OVERSAMPLE);
    localparam int MID_IDX = OVERSAMPLE / 2 - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    logic                   prev_q;
    logic [PH_W-1:0]        ph_q;
    logic [PH_W-1:0]        ph_nxt;
    logic                   fall_seen;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            // Shift the line through the synchronizer chain, idle high
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
            end
        end else begin : g_single
            // Single-stage capture of the line, idle high
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rx_in;
            end
        end
    endgenerate

    assign rx_s      = sync_q[SYNC_STAGES-1];
    assign fall_seen = tick && prev_q && !rx_s;

    // Next phase: restart on a falling edge, else wrap at the bit length
    always_comb begin
        if (fall_seen)                            ph_nxt = '0;
        else if (ph_q == PH_W'(OVERSAMPLE - 1))   ph_nxt = '0;
        else                                      ph_nxt = ph_q + 1'b1;
    end

    // Advance the phase and remember the level on every tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            prev_q <= 1'b1;
        end else if (tick) begin
            ph_q   <= ph_nxt;
            prev_q <= rx_s;
        end
    end

    assign mid_strobe = tick && (ph_nxt == PH_W'(MID_IDX));
    assign mid_level  = rx_s;

    // R4
    edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_seen |=> (ph_q == '0));

endmodule

// File: rtl/rxib_idle_timer.sv
// Counts oversampling ticks of quiet line up to a threshold and saturates
// there. A low mid-bit reading or a restart request clears the count.
// Assumes the threshold is non-zero and fits in CNT_W bits.
module rxib_idle_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mid_strobe,
    input  logic             mid_level,
    input  logic             restart,
    input  logic [CNT_W-1:0] thresh,
    output logic             idle
);
    logic [CNT_W-1:0] cnt_q;
    logic             clr;

    assign clr = restart || (mid_strobe && !mid_level);

    // Clear on activity, otherwise count ticks until the threshold
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (clr)                      cnt_q <= '0;
        else if (tick && cnt_q < thresh)   cnt_q <= cnt_q + 1'b1;
    end

    assign idle = (cnt_q >= thresh);

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q));

    // R4
    mid_low_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_strobe && !mid_level) |=> (cnt_q == '0));

    // R6
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !idle);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !clr) |=> (idle || thresh != $past(thresh)));

endmodule

// File: rtl/txb_break_gate.sv
// Chooses the transmit line level. Break wins, then mark while the
// serializer is idle, then the serializer bit. Purely combinational.
module txb_break_gate (
    input  logic brk,
    input  logic ser_bit,
    input  logic ser_idle,
    output logic line
);
    // Priority selection of the outgoing line level
    always_comb begin
        if (brk)           line = 1'b0;
        else if (ser_idle) line = 1'b1;
        else               line = ser_bit;
    end
endmodule

// File: rtl/uart_rx_idle_brk.sv
// Receive idle/timeout detector and transmit break driver.
// The idle threshold is four character times of 16 ticks per bit, taken
// from the current frame format. The timeout is idle gated by unread data.
// Assumes baud_tick pulses for one cycle and no faster than every
// SYNC_STAGES+1 cycles.
module uart_rx_idle_brk #(
    parameter int OVERSAMPLE  = 16,
    parameter int IDLE_CHARS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rx_in,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_two_stop,
    input  logic       brk_force,
    input  logic       rx_char_done,
    input  logic       fifo_nonempty,
    input  logic       fifo_read,
    input  logic       tx_ser_bit,
    input  logic       tx_ser_idle,
    output logic       rx_idle,
    output logic       rx_timeout,
    output logic       tx_line
);
    import rxib_pkg::*;

    localparam int MAX_TICKS = IDLE_CHARS * OVERSAMPLE * int'(MAX_FRAME_BITS);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    frame_cfg_t       cfg;
    logic [CNT_W-1:0] thresh;
    logic             mid_strobe;
    logic             mid_level;
    logic             restart;

    // Gather the frame fields and derive the idle threshold in ticks
    always_comb begin
        cfg.len      = cfg_len;
        cfg.par_en   = cfg_par_en;
        cfg.two_stop = cfg_two_stop;
        thresh       = CNT_W'(IDLE_CHARS * OVERSAMPLE * int'(frame_bits(cfg)));
    end

    assign restart = rx_char_done || fifo_read;

    rxib_phase_track #(
        .OVERSAMPLE  (OVERSAMPLE),
        .SYNC_STAGES (SYNC_STAGES)
    ) phase_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .rx_in      (rx_in),
        .mid_strobe (mid_strobe),
        .mid_level  (mid_level)
    );

    rxib_idle_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .mid_strobe (mid_strobe),
        .mid_level  (mid_level),
        .restart    (restart),
        .thresh     (thresh),
        .idle       (rx_idle)
    );

    assign rx_timeout = rx_idle && fifo_nonempty;

    txb_break_gate brk_i (
        .brk      (brk_force),
        .ser_bit  (tx_ser_bit),
        .ser_idle (tx_ser_idle),
        .line     (tx_line)
    );

    // R8
    read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_read |=> !rx_timeout);

    // R9
    brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_force |-> !tx_line);

    // R7
    no_data_no_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nonempty |-> !rx_timeout);

endmodule

// File: tb/uart_rx_idle_brk_tb.sv
module uart_rx_idle_brk_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       brk_force = 1'b0;
    logic       rx_char_done = 1'b0;
    logic       fifo_nonempty = 1'b0;
    logic       fifo_read = 1'b0;
    logic       tx_ser_bit = 1'b0;
    logic       tx_ser_idle = 1'b1;
    logic       rx_idle;
    logic       rx_timeout;
    logic       tx_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_idle_brk dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_two_stop(cfg_two_stop),
        .brk_force(brk_force), .rx_char_done(rx_char_done),
        .fifo_nonempty(fifo_nonempty), .fifo_read(fifo_read),
        .tx_ser_bit(tx_ser_bit), .tx_ser_idle(tx_ser_idle),
        .rx_idle(rx_idle), .rx_timeout(rx_timeout), .tx_line(tx_line)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
        end
    endtask

    // One tick, issued after enough cycles for a prior rx change to settle
    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    endtask

    task automatic pulse_done();
        @(negedge clk); rx_char_done = 1'b1;
        @(negedge clk); rx_char_done = 1'b0;
    endtask

    function automatic int exp_thresh(input int len, input int par, input int st);
        return 64 * (1 + 5 + len + par + 1 + st);
    endfunction

    initial begin
        int th;
        repeat (5) @(negedge clk);
        fifo_nonempty = 1'b1;
        #1;
        chk("R1 idle in reset", rx_idle, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", rx_idle, 1'b0);
        chk("R1 timeout after reset", rx_timeout, 1'b0);
        fifo_nonempty = 1'b0;

        // R9 / R10: break gate, all input combinations
        for (int v = 0; v < 8; v++) begin
            brk_force = v[2]; tx_ser_idle = v[1]; tx_ser_bit = v[0];
            #1;
            if (v[2])      chk("R9 break forces low", tx_line, 1'b0);
            else if (v[1]) chk("R10 idle serializer mark", tx_line, 1'b1);
            else           chk("R10 serializer bit passes", tx_line, v[0]);
        end
        brk_force = 1'b1; tx_ser_idle = 1'b0; tx_ser_bit = 1'b1; #1;
        chk("R9 break over high bit", tx_line, 1'b0);
        brk_force = 1'b0; #1;
        chk("R10 release same cycle", tx_line, 1'b1);
        tx_ser_idle = 1'b1;

        // R2 / R7: sweep all frame formats
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            cfg_len = c[1:0]; cfg_par_en = c[2]; cfg_two_stop = c[3];
            th = exp_thresh(c[1:0], c[2], c[3]);
            pulse_done();
            chk("R6 char done clears", rx_idle, 1'b0);
            tick_n(th - 1);
            chk("R2 not idle one tick early", rx_idle, 1'b0);
            tick_n(1);
            chk("R2 idle at threshold", rx_idle, 1'b1);
            chk("R7 no timeout without data", rx_timeout, 1'b0);
            fifo_nonempty = 1'b1; #1;
            chk("R7 timeout with data", rx_timeout, 1'b1);
            fifo_nonempty = 1'b0; #1;
            chk("R7 timeout follows flag", rx_timeout, 1'b0);
        end

        // R3: cycles without ticks do not count
        @(negedge clk);
        cfg_len = 2'd0; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
        th = exp_thresh(0, 0, 0);
        pulse_done();
        tick_n(th - 1);
        repeat (60) @(negedge clk);
        chk("R3 no count without tick", rx_idle, 1'b0);
        tick_n(1);
        chk("R3 one tick completes", rx_idle, 1'b1);

        // R11: stays idle through further ticks
        tick_n(40);
        chk("R11 idle holds", rx_idle, 1'b1);

        // R8: read clears the timeout and re-arms
        fifo_nonempty = 1'b1; #1;
        chk("R8 timeout before read", rx_timeout, 1'b1);
        @(negedge clk); fifo_read = 1'b1;
        @(negedge clk); fifo_read = 1'b0;
        chk("R8 read drops timeout", rx_timeout, 1'b0);
        chk("R8 read clears idle", rx_idle, 1'b0);
        tick_n(th - 1);
        chk("R8 no timeout early", rx_timeout, 1'b0);
        tick_n(1);
        chk("R8 timeout re-armed", rx_timeout, 1'b1);
        fifo_nonempty = 1'b0;

        // R5: short glitch ends before the mid sample
        rx_in = 1'b0;
        tick_n(3);
        rx_in = 1'b1;
        tick_n(12);
        chk("R5 glitch ignored", rx_idle, 1'b1);

        // R4: low through the mid sample restarts the count there
        rx_in = 1'b0;
        tick_n(8);
        chk("R4 low at mid clears", rx_idle, 1'b0);
        rx_in = 1'b1;
        tick_n(th - 1);
        chk("R4 not idle early", rx_idle, 1'b0);
        tick_n(1);
        chk("R4 idle from mid sample", rx_idle, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule